// File: doc/BRIEF.md
# Quad DAC Serial Write Interface

This block is the digital front end of a four-channel, 16-bit voltage-output converter. A host sends 32-bit frames over a three-wire port made of an active-low select line, a serial clock and a data line. All three pins are sampled on the chip's system clock, and each falling serial-clock edge is detected there. Once the 32nd bit of a frame arrives, the block decodes the frame. A frame either loads one channel's code register or replaces the per-channel power-down flags.

Each channel's 16-bit code is split into two switch codes. The upper four bits become a 15-line thermometer code for the equal-weight segment switches. The lower twelve bits drive the binary ladder switches directly. A channel that is powered down drives all of its switch lines low, and its stored code is kept.

The receiver is a four-state machine:

| State | Role |
|---|---|
| `ST_WAIT_HIGH` | Entered at reset. Waits until select is high. |
| `ST_ARMED` | Select is high. A frame may begin. |
| `ST_SHIFT` | Collecting bits. |
| `ST_HOLD` | A frame has executed. Further clock edges are ignored. |

| Transition | From | To | Condition |
|---|---|---|---|
| `go_armed` | `ST_WAIT_HIGH`, `ST_HOLD` | `ST_ARMED` | Select is high. |
| `go_shift` | `ST_ARMED` | `ST_SHIFT` | Select is low. |
| `abort` | `ST_SHIFT` | `ST_ARMED` | Select rises before the 32nd bit. |
| `finish` | `ST_SHIFT` | `ST_HOLD` | The 32nd falling edge arrives. |

Top module: `quaddac_top`

## Requirements
- R1: After reset, every channel code equals 0x8000 when `RESET_MID` is 1, or 0x0000 when it is 0. At the same time, all power-down flags are clear.
- R2: While select is low, one data bit is captured on each falling serial-clock edge, most significant bit first. Frame bit positions: bits 27:24 hold the command, bits 23:20 hold the channel address, and bits 19:4 hold the data word. Bits 31:28 and 3:0 are ignored.
- R3: A frame executes exactly once, as soon as its 32nd bit is captured. Execution does not wait for select to rise.
- R4: Command 0011 with address 0 to 3 loads the data word into that channel's code. The other channels' codes are left unchanged.
- R5: If select rises before 32 bits have arrived, the partial frame is discarded and nothing executes.
- R6: After a frame executes, serial-clock edges are ignored while select stays low. A new frame needs select to go high and then low again.
- R7: Command 0100 replaces the power-down flags with data bits 3:0. Bit c controls channel c, and 1 means powered down. Stored codes are not changed.
- R8: Any other command has no effect. A write to an address from 4 to 15 has no effect.
- R9: Thermometer line i of a powered-up channel is 1 exactly when the code's upper four bits exceed i. The number of active lines therefore equals that 4-bit value.
- R10: The 12 ladder lines of a powered-up channel equal the code's lower 12 bits.
- R11: A powered-down channel drives all thermometer and ladder lines to 0. Once its flag clears, its stored code reappears on those lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| therm_lines | output | NCH*15 | Thermometer switch lines; channel c uses bits 15c+14:15c |
| ladder_lines | output | NCH*12 | Ladder switch lines; channel c uses bits 12c+11:12c |
| chan_pd | output | NCH | Power-down flag for each channel |

## Verification
The system-clock edge that sees the 32nd falling serial edge pulses the frame-valid register one cycle later. The code or power-down register changes one cycle after that, and the switch lines follow combinationally. The bench holds each serial-clock level for at least three system cycles and checks only after a settling wait of several cycles, so every result has landed and nothing is sampled near an edge. Discarded and ignored frames are checked by reading the switch lines of all four channels against the bench's own model after the stimulus has had the same settling time.

// File: rtl/quaddac_pkg.sv
package quaddac_pkg;
    localparam int FRAME_W = 32;
    localparam int CODE_W  = 16;

    typedef enum logic [3:0] {
        CMD_LOAD = 4'b0011,
        CMD_PWDN = 4'b0100
    } cmd_e;

    typedef struct packed {
        logic [3:0]        pad_hi;
        logic [3:0]        cmd;
        logic [3:0]        addr;
        logic [CODE_W-1:0] data;
        logic [3:0]        pad_lo;
    } frame_t;

    typedef enum logic [1:0] {
        ST_WAIT_HIGH = 2'd0,
        ST_ARMED     = 2'd1,
        ST_SHIFT     = 2'd2,
        ST_HOLD      = 2'd3
    } rx_state_e;
endpackage

// File: rtl/quaddac_rx.sv
module quaddac_rx
    import quaddac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ser_clk,
    input  logic   ser_sel_n,
    input  logic   ser_din,
    output logic   frame_vld,
    output frame_t frame
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic               sclk_q;
    logic               fall;
    logic               shift_en;
    logic               done;

    assign fall = sclk_q & ~ser_clk;

    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_WAIT_HIGH: if (ser_sel_n) state_d = ST_ARMED;
            ST_ARMED:     if (!ser_sel_n) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (ser_sel_n) begin
                    state_d = ST_ARMED;
                end else if (fall) begin
                    shift_en = 1'b1;
                    if (cnt_q == LAST) begin
                        done    = 1'b1;
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD:      if (ser_sel_n) state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b1;
            cnt_q     <= '0;
            sh_q      <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            sclk_q    <= ser_clk;
            frame_vld <= done;
            if (state_q != ST_SHIFT) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (shift_en) begin
                sh_q <= {sh_q[FRAME_W-2:0], ser_din};
            end
            if (done) begin
                frame <= frame_t'({sh_q[FRAME_W-2:0], ser_din});
            end
        end
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
    a_r5_abort_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && ser_sel_n) |=> !frame_vld);
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !frame_vld);
endmodule

// File: rtl/quaddac_regs.sv
module quaddac_regs
    import quaddac_pkg::*;
#(
    parameter int NCH       = 4,
    parameter bit RESET_MID = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_vld,
    input  frame_t                       frame,
    output logic [NCH-1:0][CODE_W-1:0]   codes,
    output logic [NCH-1:0]               pd
);
    localparam logic [CODE_W-1:0] RST_CODE =
        RESET_MID ? (CODE_W'(1) << (CODE_W - 1)) : '0;

    logic is_load, is_pwdn;
    assign is_load = frame_vld && (frame.cmd == CMD_LOAD);
    assign is_pwdn = frame_vld && (frame.cmd == CMD_PWDN);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                codes[c] <= RST_CODE;
                pd[c]    <= 1'b0;
            end else begin
                if (is_load && frame.addr == 4'(c)) begin
                    codes[c] <= frame.data;
                end
                if (is_pwdn) begin
                    pd[c] <= frame.data[c];
                end
            end
        end

        a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_vld && frame.cmd == CMD_LOAD && frame.addr == 4'(c))
            |=> codes[c] == $past(frame.data));
        a_r7_pwdn_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_vld && frame.cmd == CMD_PWDN) |=> $stable(codes[c]));
    end
endmodule

// File: rtl/quaddac_seg.sv
module quaddac_seg
    import quaddac_pkg::*;
#(
    parameter int SEG_BITS = 4
) (
    input  logic [CODE_W-1:0]          code,
    input  logic                       pd,
    output logic [(1<<SEG_BITS)-2:0]   therm,
    output logic [CODE_W-SEG_BITS-1:0] ladder
);
    localparam int THERM_W  = (1 << SEG_BITS) - 1;
    localparam int LADDER_W = CODE_W - SEG_BITS;

    logic [SEG_BITS-1:0] top;
    assign top = code[CODE_W-1 -: SEG_BITS];

    for (genvar i = 0; i < THERM_W; i++) begin : g_line
        assign therm[i] = !pd && (top > SEG_BITS'(i));
    end

    assign ladder = pd ? '0 : code[LADDER_W-1:0];
endmodule

// File: rtl/quaddac_top.sv
module quaddac_top
    import quaddac_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int SEG_BITS  = 4,
    parameter bit RESET_MID = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ser_clk,
    input  logic                                   ser_sel_n,
    input  logic                                   ser_din,
    output logic [NCH*((1<<SEG_BITS)-1)-1:0]       therm_lines,
    output logic [NCH*(CODE_W-SEG_BITS)-1:0]       ladder_lines,
    output logic [NCH-1:0]                         chan_pd
);
    localparam int THERM_W  = (1 << SEG_BITS) - 1;
    localparam int LADDER_W = CODE_W - SEG_BITS;

    logic                       frame_vld;
    frame_t                     frame;
    logic [NCH-1:0][CODE_W-1:0] codes;

    quaddac_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_sel_n (ser_sel_n),
        .ser_din   (ser_din),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    quaddac_regs #(.NCH(NCH), .RESET_MID(RESET_MID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .frame     (frame),
        .codes     (codes),
        .pd        (chan_pd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_seg
        logic [THERM_W-1:0]  th;
        logic [LADDER_W-1:0] ld;

        quaddac_seg #(.SEG_BITS(SEG_BITS)) u_seg (
            .code   (codes[c]),
            .pd     (chan_pd[c]),
            .therm  (th),
            .ladder (ld)
        );
        assign therm_lines[c*THERM_W +: THERM_W]    = th;
        assign ladder_lines[c*LADDER_W +: LADDER_W] = ld;

        a_r9_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(th ^ (th >> 1)));
        a_r9_therm_count: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_pd[c] |-> $countones(th) == int'(codes[c][CODE_W-1 -: SEG_BITS]));
        a_r11_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            chan_pd[c] |-> (th == '0 && ld == '0));
    end
endmodule

// File: tb/quaddac_top_test.sv
module quaddac_top_test;
    localparam int NCH = 4;
    localparam int TW  = 15;
    localparam int LW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_sel_n = 1'b1;
    logic ser_din = 1'b0;
    logic [NCH*TW-1:0] therm_lines;
    logic [NCH*LW-1:0] ladder_lines;
    logic [NCH-1:0]    chan_pd;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_code [NCH];
    logic [NCH-1:0] m_pd;

    always #5 clk = ~clk;

    quaddac_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_clk      (ser_clk),
        .ser_sel_n    (ser_sel_n),
        .ser_din      (ser_din),
        .therm_lines  (therm_lines),
        .ladder_lines (ladder_lines),
        .chan_pd      (chan_pd)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            logic [TW-1:0] et;
            logic [LW-1:0] el;
            for (int i = 0; i < TW; i++) et[i] = !m_pd[c] && (int'(m_code[c][15:12]) > i);
            el = m_pd[c] ? '0 : m_code[c][11:0];
            check({req, " therm"}, 32'(therm_lines[c*TW +: TW]), 32'(et));
            check({req, " ladder"}, 32'(ladder_lines[c*LW +: LW]), 32'(el));
            check({req, " pd"}, 32'(chan_pd[c]), 32'(m_pd[c]));
        end
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int b = 31; b > 31 - n; b--) begin
            ser_din = w[b];
            wait_clk(2);
            ser_clk = 1'b0;
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(2);
        end
    endtask

    task automatic frame(input logic [31:0] w, input int n, input bit raise);
        ser_sel_n = 1'b1;
        wait_clk(3);
        ser_sel_n = 1'b0;
        wait_clk(3);
        shift_bits(w, n);
        wait_clk(3);
        if (raise) ser_sel_n = 1'b1;
        wait_clk(3);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cmd, input logic [3:0] addr,
                                       input logic [15:0] data);
        return {4'hA, cmd, addr, data, 4'h5};
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_code[c] = 16'h8000;
        m_pd = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1 reset");

        // R4 R9 R10: sweep every top nibble on each channel, varying ladder bits
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < 16; t++) begin
                logic [15:0] d;
                d = {4'(t), 12'(12'h5A3 ^ (t * 12'h111) ^ (c * 12'h0F0))};
                frame(mk(4'b0011, 4'(c), d), 32, (t % 2) == 0);
                m_code[c] = d;
                check_all("R4 R9 R10 R2 R3 load");
            end
        end

        // R3: select held low; result present before select rises
        ser_sel_n = 1'b1; wait_clk(3); ser_sel_n = 1'b0; wait_clk(3);
        shift_bits(mk(4'b0011, 4'd2, 16'hFFFF), 32);
        wait_clk(6);
        m_code[2] = 16'hFFFF;
        check_all("R3 exec with select low");
        // R6: more clocks with select still low are ignored
        shift_bits(mk(4'b0011, 4'd2, 16'h0000), 32);
        wait_clk(6);
        check_all("R6 trailing edges ignored");
        ser_sel_n = 1'b1; wait_clk(4);

        // R5: partial frames discarded
        frame(mk(4'b0011, 4'd1, 16'h1234), 31, 1'b1);
        check_all("R5 31-bit abort");
        frame(mk(4'b0011, 4'd0, 16'h4321), 10, 1'b1);
        check_all("R5 10-bit abort");

        // R8: other commands and bad addresses ignored
        for (int k = 0; k < 16; k++) begin
            if (k != 3 && k != 4) begin
                frame(mk(4'(k), 4'd0, 16'h000F), 32, 1'b1);
                check_all("R8 unknown cmd");
            end
        end
        frame(mk(4'b0011, 4'd4, 16'h0000), 32, 1'b1);
        frame(mk(4'b0011, 4'd15, 16'h0000), 32, 1'b1);
        check_all("R8 bad address");

        // R7 R11: power-down masks
        for (int m = 0; m < 16; m++) begin
            frame(mk(4'b0100, 4'd0, {12'hFF0, 4'(m)}), 32, 1'b1);
            m_pd = 4'(m);
            check_all("R7 R11 pd mask");
        end
        frame(mk(4'b0011, 4'd1, 16'h7ABC), 32, 1'b1);
        m_code[1] = 16'h7ABC;
        check_all("R11 load while down");
        frame(mk(4'b0100, 4'd0, 16'h0000), 32, 1'b1);
        m_pd = '0;
        check_all("R11 code returns");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule